// File: doc/BRIEF.md
# Decimating Camera Capture with Full-Resolution Window

This block sits behind a parallel camera port and turns the incoming pixel stream into writes for an on-chip frame buffer. The camera delivers each pixel as two bytes of RGB565, high byte first, while a line-valid signal is high. A frame-sync pulse starts a frame. From the full 800x600 field the block keeps only the pixels whose column and line are both even. Each kept pixel is reduced to three bits, and the result is a 400x300 thumbnail.

The buffer rows have a power-of-two stride of 512 entries. The thumbnail uses columns 0 to 399 of each row. The block places a full-resolution crop in columns 400 to 511, so the crop is 112 pixels wide and 300 lines tall. Its top-left corner in camera coordinates comes from two origin inputs. These inputs are sampled only when a frame starts. When a pixel belongs to both images, two writes are needed. The buffer has one write port, so the thumbnail write goes first and the crop write follows one cycle later. A pixel takes two clock cycles to arrive, which leaves that later slot free.

Top module: `camRoiCapture`

## Requirements
- R1: While reset is asserted, `memWe` and `frameDone` are low.
- R2: A stored pixel is the 3-bit value {red[4], green[5], blue[4]} of its RGB565 word, that is {high byte bit 7, high byte bit 2, low byte bit 4}.
- R3: A pixel at an even column x and an even line y is written once, to address (y/2)*ROW_STRIDE + x/2. The write is visible in the cycle after its low byte was sampled.
- R4: A pixel at an odd column or an odd line is never written into the thumbnail columns (0 to FRAME_W/2-1).
- R5: A pixel with x0 <= x < x0+ROI_W and y0 <= y < y0+FRAME_H/2 is written to address (y-y0)*ROW_STRIDE + FRAME_W/2 + (x-x0). Here ROI_W = ROW_STRIDE - FRAME_W/2. A window that runs past the frame edge is clipped.
- R6: When one pixel needs both writes, the thumbnail write appears in the cycle after the low byte and the crop write appears in the following cycle. No write is lost.
- R7: The origin inputs are captured on frame sync. Changes to them during a frame have no effect on that frame.
- R8: Two cycles after line-valid falls at the end of line FRAME_H-1, `frameDone` pulses high for exactly one cycle.
- R9: Lines that arrive before the first frame sync, or after a frame has completed and before the next sync, produce no writes.
- R10: Pixels beyond column FRAME_W-1 in a line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; one byte is sampled per rising edge while a line is valid |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Start-of-frame pulse; captures the window origin |
| lineValid | input | 1 | High while the bytes of a line are present |
| pixByte | input | 8 | Camera data byte |
| roiX0 | input | clog2(FRAME_W+1) | Window origin column |
| roiY0 | input | clog2(FRAME_H+1) | Window origin line |
| memWe | output | 1 | Buffer write strobe |
| memAddr | output | clog2(FRAME_H/2)+clog2(ROW_STRIDE) | Buffer write address, row in the upper bits |
| memData | output | 3 | Pixel to write, {R,G,B} |
| frameDone | output | 1 | One-cycle pulse after the final line of a frame |

## Verification
The thumbnail write and the crop write can be due in the same cycle. This happens whenever a pixel with even column and even line lies inside the window. The bench provokes it by placing the window origin at (0,0), so the first pixel of the frame needs both writes. The bench logs every write with its cycle number. It requires the thumbnail address in the cycle after the low byte and the crop address, carrying the same pixel value, exactly one cycle later. The next pixel's crop write follows in the cycle after that. Full frames with several origins are then compared entry by entry against a buffer image built from the requirements. These frames include a clipped window and an empty window, so a dropped or duplicated write shows up as a count mismatch.

// File: rtl/camCapPkg.sv
package camCapPkg;

  // Per-cycle strobes from the capture control to the datapath.
  typedef struct packed {
    logic latchHi;   // high byte of a pixel is on the bus
    logic pixDone;   // low byte on the bus completes a valid pixel
    logic keepDec;   // completed pixel belongs to the thumbnail
    logic inRoi;     // completed pixel lies inside the crop window
  } capStrobe_t;

endpackage

// File: rtl/camCapCtrl.sv
module camCapCtrl
  import camCapPkg::*;
#(
  parameter int FRAME_W    = 800,
  parameter int FRAME_H    = 600,
  parameter int ROW_STRIDE = 512
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               frameSync,
  input  logic                               lineValid,
  input  logic [$clog2(FRAME_W+1)-1:0]       roiX0,
  input  logic [$clog2(FRAME_H+1)-1:0]       roiY0,
  output capStrobe_t                         strobe,
  output logic [$clog2(ROW_STRIDE)-1:0]      decCol,
  output logic [$clog2(FRAME_H/2)-1:0]       decRow,
  output logic [$clog2(ROW_STRIDE)-1:0]      roiCol,
  output logic [$clog2(FRAME_H/2)-1:0]       roiRow,
  output logic                               frameDone
);

  localparam int XW     = $clog2(FRAME_W + 1);
  localparam int YW     = $clog2(FRAME_H + 1);
  localparam int SW     = $clog2(ROW_STRIDE);
  localparam int DEC_W  = FRAME_W / 2;
  localparam int DEC_H  = FRAME_H / 2;
  localparam int RW     = $clog2(DEC_H);
  localparam int ROI_W  = ROW_STRIDE - DEC_W;
  localparam logic [YW-1:0] LAST_Y = YW'(FRAME_H - 1);
  localparam logic [XW-1:0] X_END  = XW'(FRAME_W);

  logic          inFrame;
  logic          phase;
  logic          lineValidQ;
  logic          doneArm;
  logic          frameDoneQ;
  logic [XW-1:0] xCnt;
  logic [YW-1:0] yCnt;
  logic [XW-1:0] x0Q;
  logic [YW-1:0] y0Q;

  logic          active;
  logic          lineEnd;
  logic          inX;
  logic          inY;
  logic [XW-1:0] dx;
  logic [YW-1:0] dy;

  always_comb begin
    active  = inFrame && lineValid && !frameSync;
    lineEnd = inFrame && lineValidQ && !lineValid && !frameSync;
    dx      = xCnt - x0Q;
    dy      = yCnt - y0Q;
    inX     = (xCnt >= x0Q) && (32'(dx) < ROI_W);
    inY     = (yCnt >= y0Q) && (32'(dy) < DEC_H);

    strobe.latchHi = active && !phase;
    strobe.pixDone = active && phase && (xCnt < X_END);
    strobe.keepDec = strobe.pixDone && !xCnt[0] && !yCnt[0];
    strobe.inRoi   = strobe.pixDone && inX && inY;

    decCol = SW'(xCnt >> 1);
    decRow = RW'(yCnt >> 1);
    roiCol = SW'(32'(dx) + DEC_W);
    roiRow = RW'(dy);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame    <= 1'b0;
      phase      <= 1'b0;
      lineValidQ <= 1'b0;
      doneArm    <= 1'b0;
      frameDoneQ <= 1'b0;
      xCnt       <= '0;
      yCnt       <= '0;
      x0Q        <= '0;
      y0Q        <= '0;
    end else begin
      lineValidQ <= lineValid;
      doneArm    <= lineEnd && (yCnt == LAST_Y);
      frameDoneQ <= doneArm;
      if (frameSync) begin
        inFrame <= 1'b1;
        phase   <= 1'b0;
        xCnt    <= '0;
        yCnt    <= '0;
        x0Q     <= roiX0;
        y0Q     <= roiY0;
      end else begin
        if (lineValid && inFrame) begin
          phase <= ~phase;
          if (phase && (xCnt < X_END)) xCnt <= xCnt + 1'b1;
        end else begin
          phase <= 1'b0;
          xCnt  <= '0;
        end
        if (lineEnd) begin
          yCnt <= yCnt + 1'b1;
          if (yCnt == LAST_Y) inFrame <= 1'b0;
        end
      end
    end
  end

  assign frameDone = frameDoneQ;

  // R8: the completion flag is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R10: the column counter saturates at the frame width
  a_r10_x_bound: assert property (@(posedge clk) disable iff (!rstN)
    xCnt <= X_END);

endmodule

// File: rtl/camCapDatapath.sv
module camCapDatapath
  import camCapPkg::*;
#(
  parameter int FRAME_W    = 800,
  parameter int FRAME_H    = 600,
  parameter int ROW_STRIDE = 512
) (
  input  logic                                                 clk,
  input  logic                                                 rstN,
  input  capStrobe_t                                           strobe,
  input  logic [7:0]                                           pixByte,
  input  logic [$clog2(ROW_STRIDE)-1:0]                        decCol,
  input  logic [$clog2(FRAME_H/2)-1:0]                         decRow,
  input  logic [$clog2(ROW_STRIDE)-1:0]                        roiCol,
  input  logic [$clog2(FRAME_H/2)-1:0]                         roiRow,
  output logic                                                 memWe,
  output logic [$clog2(FRAME_H/2)+$clog2(ROW_STRIDE)-1:0]      memAddr,
  output logic [2:0]                                           memData
);

  localparam int SW    = $clog2(ROW_STRIDE);
  localparam int RW    = $clog2(FRAME_H / 2);
  localparam int AW    = RW + SW;
  localparam int DEC_W = FRAME_W / 2;

  logic [7:0]    hiQ;
  logic [15:0]   word;
  logic [4:0]    red;
  logic [5:0]    green;
  logic [4:0]    blue;
  logic [2:0]    pix3;
  logic [AW-1:0] decAddr;
  logic [AW-1:0] roiAddr;

  logic          pendValid;
  logic [AW-1:0] pendAddr;
  logic [2:0]    pendData;
  logic          weQ;
  logic [AW-1:0] addrQ;
  logic [2:0]    dataQ;
  logic          unusedColorBits;

  always_comb begin
    word    = {hiQ, pixByte};
    red     = word[15:11];
    green   = word[10:5];
    blue    = word[4:0];
    pix3    = {red[4], green[5], blue[4]};
    decAddr = {decRow, decCol};
    roiAddr = {roiRow, roiCol};
  end

  assign unusedColorBits = ^{red[3:0], green[4:0], blue[3:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
    end else if (strobe.latchHi) begin
      hiQ <= pixByte;
    end
  end

  // Single write port: thumbnail first, crop deferred into the free slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ       <= 1'b0;
      addrQ     <= '0;
      dataQ     <= '0;
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (strobe.keepDec) begin
      weQ       <= 1'b1;
      addrQ     <= decAddr;
      dataQ     <= pix3;
      pendValid <= strobe.inRoi;
      pendAddr  <= roiAddr;
      pendData  <= pix3;
    end else if (strobe.inRoi) begin
      weQ       <= 1'b1;
      addrQ     <= roiAddr;
      dataQ     <= pix3;
      pendValid <= 1'b0;
    end else if (pendValid) begin
      weQ       <= 1'b1;
      addrQ     <= pendAddr;
      dataQ     <= pendData;
      pendValid <= 1'b0;
    end else begin
      weQ       <= 1'b0;
    end
  end

  assign memWe   = weQ;
  assign memAddr = addrQ;
  assign memData = dataQ;

  // R6: a deferred crop write never meets a freshly completed pixel
  a_r6_pend_no_clash: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> !strobe.pixDone);

  // R6: a doubly-claimed pixel produces two back-to-back writes, crop second
  a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.keepDec && strobe.inRoi) |=> memWe ##1 (memWe && (32'(memAddr[SW-1:0]) >= DEC_W)));

  // R3: a thumbnail pixel lands in the left part of a row
  a_r3_dec_column: assert property (@(posedge clk) disable iff (!rstN)
    strobe.keepDec |=> (memWe && (32'(memAddr[SW-1:0]) < DEC_W)));

  // R5: a crop-only pixel lands in the right part of a row
  a_r5_roi_column: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inRoi && !strobe.keepDec) |=> (memWe && (32'(memAddr[SW-1:0]) >= DEC_W)));

endmodule

// File: rtl/camRoiCapture.sv
module camRoiCapture
  import camCapPkg::*;
#(
  parameter int FRAME_W    = 800,
  parameter int FRAME_H    = 600,
  parameter int ROW_STRIDE = 512
) (
  input  logic                                             clk,
  input  logic                                             rstN,
  input  logic                                             frameSync,
  input  logic                                             lineValid,
  input  logic [7:0]                                       pixByte,
  input  logic [$clog2(FRAME_W+1)-1:0]                     roiX0,
  input  logic [$clog2(FRAME_H+1)-1:0]                     roiY0,
  output logic                                             memWe,
  output logic [$clog2(FRAME_H/2)+$clog2(ROW_STRIDE)-1:0]  memAddr,
  output logic [2:0]                                       memData,
  output logic                                             frameDone
);

  localparam int SW = $clog2(ROW_STRIDE);
  localparam int RW = $clog2(FRAME_H / 2);

  capStrobe_t    strobe;
  logic [SW-1:0] decCol;
  logic [RW-1:0] decRow;
  logic [SW-1:0] roiCol;
  logic [RW-1:0] roiRow;

  camCapCtrl #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .ROW_STRIDE(ROW_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .lineValid(lineValid),
    .roiX0(roiX0), .roiY0(roiY0), .strobe(strobe),
    .decCol(decCol), .decRow(decRow), .roiCol(roiCol), .roiRow(roiRow),
    .frameDone(frameDone)
  );

  camCapDatapath #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .ROW_STRIDE(ROW_STRIDE)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixByte(pixByte),
    .decCol(decCol), .decRow(decRow), .roiCol(roiCol), .roiRow(roiRow),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

endmodule

// File: tb/camRoiCapture_bench.sv
module camRoiCapture_bench;

  localparam int FW    = 16;
  localparam int FH    = 8;
  localparam int ST    = 16;
  localparam int XW    = $clog2(FW + 1);
  localparam int YW    = $clog2(FH + 1);
  localparam int AW    = $clog2(FH / 2) + $clog2(ST);
  localparam int DW    = FW / 2;
  localparam int DH    = FH / 2;
  localparam int RWIN  = ST - DW;
  localparam int DEPTH = DH * ST;

  // Vector: {x0[4:0], y0[3:0], seed[7:0], midChange, extraPixels[2:0]}
  localparam int NVEC = 5;
  localparam logic [20:0] VEC [NVEC] = '{
    {5'd0,  4'd0, 8'd3,  1'b0, 3'd0},
    {5'd8,  4'd4, 8'd9,  1'b1, 3'd0},
    {5'd12, 4'd6, 8'd21, 1'b0, 3'd2},
    {5'd5,  4'd1, 8'd44, 1'b1, 3'd3},
    {5'd16, 4'd0, 8'd7,  1'b0, 3'd0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          frameSync = 1'b0;
  logic          lineValid = 1'b0;
  logic [7:0]    pixByte = '0;
  logic [XW-1:0] roiX0 = '0;
  logic [YW-1:0] roiY0 = '0;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [2:0]    memData;
  logic          frameDone;

  camRoiCapture #(.FRAME_W(FW), .FRAME_H(FH), .ROW_STRIDE(ST)) u_camRoiCapture (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .lineValid(lineValid),
    .pixByte(pixByte), .roiX0(roiX0), .roiY0(roiY0), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .frameDone(frameDone)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail = 0;

  // Write monitor
  int       frameId = 0;
  int       wrCount = 0;
  int       dupCount = 0;
  int       doneCount = 0;
  int       doneCyc = 0;
  int       gotTag [DEPTH];
  logic [2:0] gotMem [DEPTH];
  int       logAddr [256];
  int       logCyc [256];
  logic [2:0] logData [256];

  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        if (gotTag[memAddr] == frameId) dupCount = dupCount + 1;
        gotTag[memAddr] = frameId;
        gotMem[memAddr] = memData;
        logAddr[wrCount % 256] = int'(memAddr);
        logCyc[wrCount % 256]  = cyc;
        logData[wrCount % 256] = memData;
        wrCount = wrCount + 1;
      end
      if (frameDone) begin
        doneCount = doneCount + 1;
        doneCyc = cyc;
      end
    end
  end

  logic [2:0] expMem [DEPTH];
  bit         expW [DEPTH];

  function automatic logic [7:0] hiOf(int x, int y, int s);
    return 8'(x * 37 + y * 91 + s * 5);
  endfunction

  function automatic logic [7:0] loOf(int x, int y, int s);
    return 8'((x * 53) ^ (y * 29) ^ (s * 17));
  endfunction

  function automatic logic [2:0] pixOf(int x, int y, int s);
    logic [7:0] h;
    logic [7:0] l;
    h = hiOf(x, y, s);
    l = loOf(x, y, s);
    return {h[7], h[2], l[4]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic buildExpected(int x0, int y0, int s, output int n);
    n = 0;
    for (int a = 0; a < DEPTH; a++) expW[a] = 1'b0;
    for (int y = 0; y < FH; y++) begin
      for (int x = 0; x < FW; x++) begin
        if ((x % 2 == 0) && (y % 2 == 0)) begin
          expMem[(y / 2) * ST + x / 2] = pixOf(x, y, s);
          expW[(y / 2) * ST + x / 2] = 1'b1;
          n++;
        end
        if (x >= x0 && x < x0 + RWIN && y >= y0 && y < y0 + DH) begin
          expMem[(y - y0) * ST + DW + (x - x0)] = pixOf(x, y, s);
          expW[(y - y0) * ST + DW + (x - x0)] = 1'b1;
          n++;
        end
      end
    end
  endtask

  task automatic driveLine(int y, int s, int extra, output int startCyc, output int dropCyc);
    startCyc = cyc;
    for (int x = 0; x < FW + extra; x++) begin
      lineValid = 1'b1;
      pixByte = hiOf(x, y, s);
      @(negedge clk);
      pixByte = loOf(x, y, s);
      @(negedge clk);
    end
    lineValid = 1'b0;
    pixByte = '0;
    dropCyc = cyc;
    repeat (3) @(negedge clk);
  endtask

  task automatic runFrame(int x0, int y0, int s, bit chg, int extra,
                          output int firstCyc, output int lastDrop);
    int st;
    int dr;
    roiX0 = XW'(x0);
    roiY0 = YW'(y0);
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
    if (chg) begin
      roiX0 = XW'((x0 + 3) % (FW + 1));
      roiY0 = YW'((y0 + 2) % (FH + 1));
    end
    repeat (2) @(negedge clk);
    firstCyc = 0;
    lastDrop = 0;
    for (int y = 0; y < FH; y++) begin
      driveLine(y, s, extra, st, dr);
      if (y == 0) firstCyc = st;
      lastDrop = dr;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks = nChecks + 1;
    nFail = nFail + 1;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int st;
    int dr;
    int base;
    int baseDone;
    int baseDup;
    int nExp;
    int mism;
    int x0;
    int y0;
    int sd;
    bit chg;
    int ex;

    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(memWe == 1'b0, "R1 memWe in reset", int'(memWe), 0);
    check(frameDone == 1'b0, "R1 frameDone in reset", int'(frameDone), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9: a line before any frame sync writes nothing
    base = wrCount;
    driveLine(0, 2, 0, st, dr);
    check(wrCount == base, "R9 line before first sync", wrCount - base, 0);

    // Table of frames: origin, seed, mid-frame origin change (R7), extra pixels (R10)
    for (int i = 0; i < NVEC; i++) begin
      x0  = int'(VEC[i][20:16]);
      y0  = int'(VEC[i][15:12]);
      sd  = int'(VEC[i][11:4]);
      chg = VEC[i][3];
      ex  = int'(VEC[i][2:0]);
      frameId = frameId + 1;
      buildExpected(x0, y0, sd, nExp);
      base = wrCount;
      baseDone = doneCount;
      baseDup = dupCount;
      runFrame(x0, y0, sd, chg, ex, st, dr);
      mism = dupCount - baseDup;
      for (int a = 0; a < DEPTH; a++) begin
        if ((gotTag[a] == frameId) != expW[a]) mism++;
        else if (expW[a] && gotMem[a] !== expMem[a]) mism++;
      end
      // R2 R3 R4 R5 (and R7 when the origin moved mid-frame)
      check(mism == 0, chg ? "R2 R3 R5 R7 buffer contents" : "R2 R3 R4 R5 buffer contents",
            mism, 0);
      // R4 R10: no stray writes, extra pixels dropped
      check(wrCount - base == nExp, "R4 R10 write count", wrCount - base, nExp);
      // R8: single pulse two cycles after the final drop of line-valid
      check(doneCount - baseDone == 1, "R8 frameDone pulse count", doneCount - baseDone, 1);
      check(doneCyc - dr == 2, "R8 frameDone delay", doneCyc - dr, 2);
    end

    // R6: window at origin, first pixel needs both writes
    frameId = frameId + 1;
    base = wrCount;
    runFrame(0, 0, 1, 1'b0, 0, st, dr);
    check(logAddr[base % 256] == 0 && logCyc[base % 256] == st + 2,
          "R6 thumbnail write cycle", logCyc[base % 256] - st, 2);
    check(logAddr[(base + 1) % 256] == DW && logCyc[(base + 1) % 256] == st + 3,
          "R6 deferred crop write cycle", logCyc[(base + 1) % 256] - st, 3);
    check(logData[(base + 1) % 256] == pixOf(0, 0, 1),
          "R6 deferred crop data", int'(logData[(base + 1) % 256]), int'(pixOf(0, 0, 1)));
    check(logAddr[(base + 2) % 256] == DW + 1 && logCyc[(base + 2) % 256] == st + 4,
          "R6 next crop write", logAddr[(base + 2) % 256], DW + 1);

    // R9: after frame completion, lines without a new sync write nothing
    base = wrCount;
    driveLine(0, 5, 0, st, dr);
    driveLine(1, 5, 0, st, dr);
    check(wrCount == base, "R9 line after frame end", wrCount - base, 0);

    summary();
    $finish;
  end

endmodule